// File: doc/BRIEF.md
# Card Window Address Decoder

This block holds eight programmable address windows for a 16-bit PC-card socket controller and decides, for every host access, which window (if any) claims it. Each window is described by a base word and an option word, both written through a simple register bus. The option word marks the window valid, picks the card slot, the access space (common memory, attribute memory or I/O), the data width, write protection, three timing fields and a 5-bit size code. The size code maps to a power-of-two size through a scrambled table, and some code values are reserved.

The decoder is purely a claim-and-describe stage. A host access presents an address, a valid strobe and a write flag. In the same cycle the block reports whether a window hit, which window won, and that window's attributes. It also reports whether the access may be forwarded or was stopped as a write-protect violation. Host addresses pass to the card unchanged: there is no offset translation, so a window's base must be aligned to its size. The card bus cycle itself is produced elsewhere.

Register writes take effect on the clock edge that samples them. Software disables a window by writing zero to its option word before it changes the base.

Top module: `cwin_decoder`

## Requirements
- R1: After a synchronous active-low reset, every base and option word reads back as zero and no access hits.
- R2: Register address 2*w holds the base of window w and address 2*w+1 holds its option word. All 32 bits written are read back unchanged on reg_rd_data for the address on reg_rd_addr.
- R3: A window hits an access with acc_valid high when option bit 0 (valid) is set and the address matches the base in every bit at or above log2 of the window size. Size codes in option bits 31:27 map to log2 sizes as follows: 0→0, 1→1, 2→3, 3→2, 4→7, 5→6, 6→4, 7→5, 8→15, 9→14, 10→12, 11→13, 12→8, 13→9, 14→11, 15→10, 20→24, 21→25, 23→26, 24→16, 25→17, 26→19, 27→18, 28→23, 29→22, 30→20, 31→21.
- R4: Size codes 16, 17, 18, 19 and 22 are invalid, and a window that carries one never hits.
- R5: Option bits 4:3 give the space, and hit_space reports them: 00 is common memory, 10 is attribute memory, 11 is I/O. The value 01 is reserved, and such a window never hits.
- R6: When several windows hit, hit_win reports the lowest-numbered one, and all attributes come from that window.
- R7: On a hit, hit_slot reports option bit 2, hit_wide reports bit 6, t_strobe reports bits 11:7, t_setup reports bits 15:12 and t_hold reports bits 19:16. With no hit, all of hit, hit_win and the attribute outputs are zero.
- R8: A write (acc_write high) that hits a window with option bit 1 set raises wp_viol and holds acc_fwd low. Any other hit, including a read of a protected window, raises acc_fwd with wp_viol low.
- R9: Writing zero to an option word stops that window from hitting from the next cycle on.
- R10: With acc_valid low, hit, acc_fwd and wp_viol stay low whatever the window contents are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write address (2*w base, 2*w+1 option) |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register read address |
| reg_rd_data | output | 32 | Register read data, combinational |
| acc_valid | input | 1 | Host access present |
| acc_write | input | 1 | Host access is a write |
| acc_addr | input | 32 | Host access address |
| hit | output | 1 | Some window claims the access |
| hit_win | output | 3 | Index of the winning window |
| hit_slot | output | 1 | Card slot of the winning window |
| hit_space | output | 2 | Space of the winning window |
| hit_wide | output | 1 | Winning window is 16 bits wide |
| wp_viol | output | 1 | Write to a protected window, not forwarded |
| acc_fwd | output | 1 | Access may be forwarded to the card |
| t_strobe | output | 5 | Strobe-length timing field |
| t_setup | output | 4 | Setup timing field |
| t_hold | output | 4 | Hold timing field |

## Verification
The assertions check several rules on every cycle. Registers are clear right after reset. The reported winner is a hitting window with no lower-numbered hitter. A window with a reserved size code never claims an access. A zeroed option word blocks its window on the next cycle. A violation only occurs for a valid write. The scrambled size-code table, the exact masked comparison at each window-size boundary, the attribute fields of the winner and register readback are shown only by the bench scenarios. These compare outputs against an independent model over directed boundary addresses and a random mix of window setups and accesses.

// File: rtl/cwin_pkg.sv
// Shared types and the size-code decode for the card window decoder.
// Assumes option words use the bit layout described in the brief.
package cwin_pkg;

    typedef enum logic [1:0] {
        SP_COMMON = 2'b00,
        SP_RSVD   = 2'b01,
        SP_ATTR   = 2'b10,
        SP_IO     = 2'b11
    } space_t;

    // Decoded window attributes held per window
    typedef struct packed {
        logic [4:0] code;
        logic [3:0] hold;
        logic [3:0] setup;
        logic [4:0] strobe;
        logic       wide;
        space_t     space;
        logic       slot;
        logic       wprot;
        logic       valid;
    } win_cfg_t;

    typedef struct packed {
        logic       ok;
        logic [4:0] lg2;
    } size_dec_t;

    // Map the scrambled 5-bit size code to log2 of the window size
    function automatic size_dec_t size_decode(input logic [4:0] code);
        size_dec_t r;
        r.ok = 1'b1;
        case (code)
            5'd0:  r.lg2 = 5'd0;
            5'd1:  r.lg2 = 5'd1;
            5'd2:  r.lg2 = 5'd3;
            5'd3:  r.lg2 = 5'd2;
            5'd4:  r.lg2 = 5'd7;
            5'd5:  r.lg2 = 5'd6;
            5'd6:  r.lg2 = 5'd4;
            5'd7:  r.lg2 = 5'd5;
            5'd8:  r.lg2 = 5'd15;
            5'd9:  r.lg2 = 5'd14;
            5'd10: r.lg2 = 5'd12;
            5'd11: r.lg2 = 5'd13;
            5'd12: r.lg2 = 5'd8;
            5'd13: r.lg2 = 5'd9;
            5'd14: r.lg2 = 5'd11;
            5'd15: r.lg2 = 5'd10;
            5'd20: r.lg2 = 5'd24;
            5'd21: r.lg2 = 5'd25;
            5'd23: r.lg2 = 5'd26;
            5'd24: r.lg2 = 5'd16;
            5'd25: r.lg2 = 5'd17;
            5'd26: r.lg2 = 5'd19;
            5'd27: r.lg2 = 5'd18;
            5'd28: r.lg2 = 5'd23;
            5'd29: r.lg2 = 5'd22;
            5'd30: r.lg2 = 5'd20;
            5'd31: r.lg2 = 5'd21;
            default: begin
                r.ok  = 1'b0;
                r.lg2 = 5'd0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cwin_regbank.sv
// Register bank: base and option word per window, written over a simple
// register bus, read back combinationally. Exposes decoded attributes.
// Assumes word address 2*w is the base and 2*w+1 the option of window w.
module cwin_regbank
    import cwin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int DATA_W  = 32,
    localparam int RA_W   = $clog2(2 * NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] base_q [NUM_WIN],
    output win_cfg_t          cfg_q  [NUM_WIN]
);

    logic [DATA_W-1:0] opt_q [NUM_WIN];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        // Store base and option words for window w
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[w] <= '0;
                opt_q[w]  <= '0;
            end else if (wr_en && (wr_addr[RA_W-1:1] == (RA_W-1)'(w))) begin
                if (wr_addr[0]) opt_q[w]  <= wr_data;
                else            base_q[w] <= wr_data;
            end
        end

        // Split the option word into named fields
        always_comb begin
            cfg_q[w].valid  = opt_q[w][0];
            cfg_q[w].wprot  = opt_q[w][1];
            cfg_q[w].slot   = opt_q[w][2];
            cfg_q[w].space  = space_t'(opt_q[w][4:3]);
            cfg_q[w].wide   = opt_q[w][6];
            cfg_q[w].strobe = opt_q[w][11:7];
            cfg_q[w].setup  = opt_q[w][15:12];
            cfg_q[w].hold   = opt_q[w][19:16];
            cfg_q[w].code   = opt_q[w][31:27];
        end
    end

    // Read mux over both words of every window
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (rd_addr[RA_W-1:1] == (RA_W-1)'(w))
                rd_data = rd_addr[0] ? opt_q[w] : base_q[w];
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
        AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (!cfg_q[w].valid && base_q[w] == '0)); // R1
    end

endmodule

// File: rtl/cwin_match.sv
// One window comparator: masks address and base to the decoded window
// size and compares. Assumes the base is aligned to the window size.
module cwin_match
    import cwin_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] base,
    input  logic              valid,
    input  space_t            space,
    input  logic [4:0]        code,
    output logic              hit
);

    size_dec_t         sz;
    logic [ADDR_W-1:0] mask;

    // Decode size and build the upper-bit compare mask
    always_comb begin
        sz   = size_decode(code);
        mask = {ADDR_W{1'b1}} << sz.lg2;
    end

    // Window claims the access when enabled and the masked bits agree
    always_comb begin
        hit = acc_valid && valid && sz.ok && (space != SP_RSVD) &&
              (((acc_addr ^ base) & mask) == '0);
    end

endmodule

// File: rtl/cwin_prio.sv
// Fixed-priority selector: lowest-numbered set bit of the hit vector wins.
// Assumes NUM_WIN is at least two.
module cwin_prio #(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WIN-1:0] hit_vec,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    // Scan from high to low so the lowest hitter is kept last
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (hit_vec[idx] &&
                 ((hit_vec & ((NUM_WIN'(1) << idx) - NUM_WIN'(1))) == '0))); // R6

    AST_PRIO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec == '0) |-> !any); // R6

endmodule

// File: rtl/cwin_decoder.sv
// Top of the card window address decoder. Instantiates the register bank,
// one comparator per window and the priority selector, then reports the
// winner's attributes and the write-protect outcome combinationally.
// Assumes register writes apply on the sampling edge; outputs are zero
// when no window hits.
module cwin_decoder
    import cwin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int ADDR_W  = 32,
    localparam int RA_W   = $clog2(2 * NUM_WIN),
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic [RA_W-1:0]   reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_win,
    output logic              hit_slot,
    output logic [1:0]        hit_space,
    output logic              hit_wide,
    output logic              wp_viol,
    output logic              acc_fwd,
    output logic [4:0]        t_strobe,
    output logic [3:0]        t_setup,
    output logic [3:0]        t_hold
);

    logic [31:0]        base_q [NUM_WIN];
    win_cfg_t           cfg_q  [NUM_WIN];
    logic [NUM_WIN-1:0] hit_vec;
    logic               any_hit;
    logic [IDX_W-1:0]   win_idx;

    cwin_regbank #(.NUM_WIN(NUM_WIN), .DATA_W(32)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_addr),
        .wr_data (reg_wr_data),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data),
        .base_q  (base_q),
        .cfg_q   (cfg_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        cwin_match #(.ADDR_W(ADDR_W)) u_match (
            .acc_addr  (acc_addr),
            .acc_valid (acc_valid),
            .base      (ADDR_W'(base_q[w])),
            .valid     (cfg_q[w].valid),
            .space     (cfg_q[w].space),
            .code      (cfg_q[w].code),
            .hit       (hit_vec[w])
        );
    end

    cwin_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_vec (hit_vec),
        .any     (any_hit),
        .idx     (win_idx)
    );

    // Report the winner's attributes, all zero on a miss
    always_comb begin
        hit       = any_hit;
        hit_win   = any_hit ? win_idx : '0;
        hit_slot  = any_hit & cfg_q[win_idx].slot;
        hit_space = any_hit ? cfg_q[win_idx].space : 2'b00;
        hit_wide  = any_hit & cfg_q[win_idx].wide;
        t_strobe  = any_hit ? cfg_q[win_idx].strobe : '0;
        t_setup   = any_hit ? cfg_q[win_idx].setup  : '0;
        t_hold    = any_hit ? cfg_q[win_idx].hold   : '0;
    end

    // Block writes into a protected window, forward everything else
    always_comb begin
        wp_viol = any_hit && acc_write && cfg_q[win_idx].wprot;
        acc_fwd = any_hit && !wp_viol;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!hit && !acc_fwd && !wp_viol)); // R10

    AST_VIOL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wp_viol |-> (acc_write && hit && !acc_fwd)); // R8

    AST_ZERO_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr[0] && reg_wr_data == 32'd0)
        |=> !hit_vec[$past(reg_addr[RA_W-1:1])]); // R9

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
        AST_BAD_CODE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[w].code inside {5'd16, 5'd17, 5'd18, 5'd19, 5'd22})
            |-> !hit_vec[w]); // R4
    end

endmodule

// File: tb/tb_cwin_decoder.sv
// Bench for the card window decoder: directed corner cases plus seeded
// random window setups and accesses, compared against a bench model.
module tb_cwin_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [3:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        hit, hit_slot, hit_wide, wp_viol, acc_fwd;
    logic [2:0]  hit_win;
    logic [1:0]  hit_space;
    logic [4:0]  t_strobe;
    logic [3:0]  t_setup, t_hold;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] base_m [8];
    logic [31:0] opt_m  [8];

    always #5 clk = ~clk;

    cwin_decoder dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_addr(acc_addr), .hit(hit),
        .hit_win(hit_win), .hit_slot(hit_slot), .hit_space(hit_space),
        .hit_wide(hit_wide), .wp_viol(wp_viol), .acc_fwd(acc_fwd),
        .t_strobe(t_strobe), .t_setup(t_setup), .t_hold(t_hold)
    );

    function automatic int lg_of(input logic [4:0] c);
        case (c)
            0: return 0;   1: return 1;   2: return 3;   3: return 2;
            4: return 7;   5: return 6;   6: return 4;   7: return 5;
            8: return 15;  9: return 14;  10: return 12; 11: return 13;
            12: return 8;  13: return 9;  14: return 11; 15: return 10;
            20: return 24; 21: return 25; 23: return 26; 24: return 16;
            25: return 17; 26: return 19; 27: return 18; 28: return 23;
            29: return 22; 30: return 20; 31: return 21;
            default: return -1;
        endcase
    endfunction

    function automatic logic [22:0] model(input logic v, input logic w,
                                          input logic [31:0] a);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] o;
            int lg;
            o  = opt_m[i];
            lg = lg_of(o[31:27]);
            if (v && o[0] && lg >= 0 && o[4:3] != 2'b01 &&
                (((a ^ base_m[i]) >> lg) == 32'd0)) begin
                logic viol;
                viol = w & o[1];
                return {1'b1, 3'(i), o[2], o[4:3], o[6], viol, !viol,
                        o[11:7], o[15:12], o[19:16]};
            end
        end
        return '0;
    endfunction

    function automatic logic [22:0] actual();
        return {hit, hit_win, hit_slot, hit_space, hit_wide, wp_viol, acc_fwd,
                t_strobe, t_setup, t_hold};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        if (a[0]) opt_m[a[3:1]] = d; else base_m[a[3:1]] = d;
        @(negedge clk);
    endtask

    task automatic acc(input string req, input logic v, input logic w,
                       input logic [31:0] a);
        acc_valid = v; acc_write = w; acc_addr = a;
        #2;
        check(req, 32'(actual()), 32'(model(v, w, a)));
    endtask

    function automatic logic [31:0] mk_opt(input logic [4:0] code,
            input logic [1:0] sp, input logic wp, input logic slot,
            input logic wide, input logic v);
        return {code, 7'd0, 4'h5, 4'hA, 5'h13, wide, 1'b0, sp, slot, wp, v};
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 8; i++) begin base_m[i] = '0; opt_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            reg_rd_addr = 4'(a); #1;
            check("R1 readback", reg_rd_data, 32'd0);
        end
        acc("R1 no hit", 1'b1, 1'b0, 32'h0000_0000);
        check("R1 hit low", {31'd0, hit}, 32'd0);

        // R2: register map and readback
        wr(4'd6, 32'hCAFE_F00D);
        wr(4'd7, 32'h0123_4566);
        reg_rd_addr = 4'd6; #1; check("R2 base w3", reg_rd_data, 32'hCAFE_F00D);
        reg_rd_addr = 4'd7; #1; check("R2 opt w3", reg_rd_data, 32'h0123_4566);
        wr(4'd7, 32'd0);

        // R3: 4K window boundaries and 4-byte window boundaries
        wr(4'd0, 32'h1000_0000);
        wr(4'd1, mk_opt(5'd10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1));
        acc("R3 4K inside", 1'b1, 1'b0, 32'h1000_0ABC);
        check("R3 4K hit", {31'd0, hit}, 32'd1);
        acc("R3 4K top", 1'b1, 1'b0, 32'h1000_0FFF);
        acc("R3 4K past", 1'b1, 1'b0, 32'h1000_1000);
        check("R3 4K miss", {31'd0, hit}, 32'd0);
        wr(4'd2, 32'h2000_0000);
        wr(4'd3, mk_opt(5'd3, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1));
        acc("R3 4B last", 1'b1, 1'b0, 32'h2000_0003);
        acc("R3 4B past", 1'b1, 1'b0, 32'h2000_0004);
        check("R3 4B miss", {31'd0, hit}, 32'd0);

        // R7: attributes of window 1 (I/O, slot B, 16-bit)
        acc("R7 attrs", 1'b1, 1'b0, 32'h2000_0001);
        check("R7 slot/space/wide", {28'd0, hit_slot, hit_space, hit_wide},
              {28'd0, 1'b1, 2'b11, 1'b1});
        check("R7 timing", {19'd0, t_strobe, t_setup, t_hold},
              {19'd0, 5'h13, 4'hA, 4'h5});

        // R4: invalid size codes never hit
        wr(4'd4, 32'h3000_0000);
        for (int c = 16; c < 23; c++) begin
            if (c == 16 || c == 17 || c == 18 || c == 19 || c == 22) begin
                wr(4'd5, mk_opt(5'(c), 2'b00, 1'b0, 1'b0, 1'b0, 1'b1));
                acc("R4 bad code", 1'b1, 1'b0, 32'h3000_0000);
                check("R4 miss", {31'd0, hit}, 32'd0);
            end
        end

        // R5: reserved space misses, attribute space reported
        wr(4'd5, mk_opt(5'd12, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1));
        acc("R5 rsvd space", 1'b1, 1'b0, 32'h3000_0010);
        check("R5 rsvd miss", {31'd0, hit}, 32'd0);
        wr(4'd5, mk_opt(5'd12, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1));
        acc("R5 attr space", 1'b1, 1'b0, 32'h3000_0010);
        check("R5 attr", {30'd0, hit_space}, 32'd2);

        // R6: overlapping windows 4 and 5, lowest wins
        wr(4'd8, 32'h4000_0000);
        wr(4'd9, mk_opt(5'd8, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1));
        wr(4'd10, 32'h4000_0000);
        wr(4'd11, mk_opt(5'd10, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1));
        acc("R6 overlap", 1'b1, 1'b0, 32'h4000_0100);
        check("R6 winner", {29'd0, hit_win}, 32'd4);

        // R8: write-protect
        wr(4'd13, mk_opt(5'd9, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1));
        wr(4'd12, 32'h5000_0000);
        acc("R8 wp write", 1'b1, 1'b1, 32'h5000_0040);
        check("R8 viol", {30'd0, wp_viol, acc_fwd}, 32'd2);
        acc("R8 wp read", 1'b1, 1'b0, 32'h5000_0040);
        check("R8 read fwd", {30'd0, wp_viol, acc_fwd}, 32'd1);

        // R9: zero option disables window next cycle
        wr(4'd13, 32'd0);
        acc("R9 disabled", 1'b1, 1'b0, 32'h5000_0040);
        check("R9 miss", {31'd0, hit}, 32'd0);

        // R10: no access, no hit
        acc("R10 idle", 1'b0, 1'b1, 32'h1000_0000);
        check("R10 quiet", {29'd0, hit, acc_fwd, wp_viol}, 32'd0);

        // R3: random window setups and accesses against the model
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 4) == 0) begin
                int w;
                logic [31:0] o;
                int lg;
                w = $urandom % 8;
                o = $urandom;
                if (($urandom % 4) != 0) o[0] = 1'b1;
                lg = lg_of(o[31:27]);
                wr(4'(2 * w + 1), 32'd0);
                wr(4'(2 * w), (lg >= 0) ? ($urandom & ({32{1'b1}} << lg))
                                        : $urandom);
                wr(4'(2 * w + 1), o);
            end else begin
                int w;
                logic [31:0] a;
                int lg;
                w  = $urandom % 8;
                lg = lg_of(opt_m[w][31:27]);
                a  = (lg >= 0) ? (base_m[w] ^ ($urandom & ~({32{1'b1}} << lg)))
                               : $urandom;
                if (($urandom % 5) == 0) a = a ^ (32'd1 << ($urandom % 32));
                acc("R3 random", ($urandom % 8) != 0, $urandom % 2, a);
                @(negedge clk);
            end
        end

        acc_valid = 1'b0;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule